// File: doc/BRIEF.md
# Pixel Word Packer with Output Queue

This block takes a stream of already processed pixels and assembles them into 32-bit words for a wide memory port. A 2-bit format select chooses how pixels map onto the word: two 16-bit RGB pixels with a key bit, two pixels of 4:2:2 luma/chroma, one luma/chroma pair in the upper half of a word for test, or four 8-bit grey pixels. A keep strobe marks each pixel that belongs in the output. An end-of-line marker closes any partly filled word and pads the empty lanes with a fill value that depends on the format.

Completed words go into a 16-word queue. The consumer side pops words with a read enable. A flag reports when the queue holds half of its capacity or more, and a sticky flag records that a word was lost because the queue was full. The read side is clocked by the same clock as the write side. The format select and the chroma representation must stay constant for the whole of a line.

Top module: `pxpk_top`

## Requirements
- R1: With format code 0, each word holds two pixels. The first pixel of the pair is in bits 31:16 and the second in bits 15:0. Each 16-bit half is {key, red[7:3], green[7:3], blue[7:3]}, with the key bit at the top.
- R2: With format code 1, each word holds two pixels. Bits 31:16 are {luma of the even pixel, U}. Bits 15:0 are {luma of the odd pixel, V}.
- R3: With format code 2, each pixel makes a word of its own: {luma, chroma, 16'h0000}. The chroma is U for even pixels and V for odd pixels, counted from the start of the line.
- R4: With format code 3, each word holds four consecutive pixel lumas. The first pixel is in bits 31:24 and the fourth in bits 7:0.
- R5: When a line ends partway through a word, that word is still written, and its unfilled lanes carry fill values. RGB halves are 16'h0000. Luma is 8'h00. Chroma is 8'h80 when chroma is straight binary and 8'h00 when it is two's complement. Grey bytes are 8'hFF.
- R6: An end-of-line marker that arrives with no partial word pending writes nothing. The next pixel always begins a new word as pixel 0, which is even.
- R7: Words leave the queue in the order they were written. A word becomes readable on the second rising edge after its last pixel is sampled. The queue holds up to 16 words, and the empty output is high when it holds none.
- R8: The half-full flag is high exactly while the queue holds 8 or more words.
- R9: A word that arrives while the queue holds 16 words is dropped. Dropping a word sets the overflow flag, which stays set until reset.
- R10: A read while the queue is empty leaves the read data at its previous value and changes no state.
- R11: After reset, the queue is empty, both flags are low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the pixel side and the read side |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Packing format code, 0 to 3 |
| chroma_tc | input | 1 | 1 means chroma is two's complement, which selects the chroma fill value |
| pix_keep | input | 1 | The pixel on the data inputs belongs in the output |
| line_last | input | 1 | End of line; it may coincide with the last kept pixel |
| pix_key | input | 1 | Key bit for the RGB format |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_y | input | 8 | Luma |
| pix_u | input | 8 | Chroma U |
| pix_v | input | 8 | Chroma V |
| rd_en | input | 1 | Pop one word from the queue |
| rd_data | output | 32 | Word loaded by the most recent successful pop |
| q_empty | output | 1 | The queue holds no words |
| q_half | output | 1 | The queue holds 8 or more words |
| q_ovf | output | 1 | Sticky flag: a word was dropped |

## Verification
A pixel sampled on an edge that completes or closes a word is registered inside the packer on that same edge. The word then enters the queue on the next edge, so the empty and half-full flags change one edge after the completing pixel. A pop presents its word on rd_data right after the edge that samples rd_en. The bench's reference model follows these same delays: a one-slot pending stage in front of a queue. It compares rd_data and all three flags in every cycle, sampling at the falling edge, halfway between the edges where inputs are sampled and outputs change.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
   typedef enum logic [1:0] {
      PK_RGB15 = 2'd0,
      PK_YUV2  = 2'd1,
      PK_TEST  = 2'd2,
      PK_GREY4 = 2'd3
   } pk_fmt_e;

   // lanes a word holds, minus one
   function automatic logic [1:0] last_lane(input pk_fmt_e f);
      case (f)
         PK_RGB15, PK_YUV2: last_lane = 2'd1;
         PK_TEST:           last_lane = 2'd0;
         default:           last_lane = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/pxpk_fill.sv
module pxpk_fill
   import pxpk_pkg::*;
#(
   parameter int COMP_W = 8,
   localparam int WORD_W = 4 * COMP_W
) (
   input  pk_fmt_e             fmt,
   input  logic                chroma_tc,
   output logic [WORD_W-1:0]   fill_word
);
   localparam logic [COMP_W-1:0] MID  = COMP_W'(1) << (COMP_W - 1);
   localparam logic [COMP_W-1:0] ZERO = '0;

   logic [COMP_W-1:0] c_fill;
   assign c_fill = chroma_tc ? ZERO : MID;

   always_comb begin
      case (fmt)
         PK_YUV2:  fill_word = {ZERO, c_fill, ZERO, c_fill};
         PK_GREY4: fill_word = '1;
         default:  fill_word = '0;
      endcase
   end
endmodule

// File: rtl/pxpk_packer.sv
module pxpk_packer
   import pxpk_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int RGB_W  = 5,
   localparam int WORD_W = 4 * COMP_W,
   localparam int HALF_W = 2 * COMP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pk_fmt_e            fmt,
   input  logic               chroma_tc,
   input  logic               keep,
   input  logic               eol,
   input  logic               key,
   input  logic [COMP_W-1:0]  r,
   input  logic [COMP_W-1:0]  g,
   input  logic [COMP_W-1:0]  b,
   input  logic [COMP_W-1:0]  y,
   input  logic [COMP_W-1:0]  u,
   input  logic [COMP_W-1:0]  v,
   output logic               wr_en,
   output logic [WORD_W-1:0]  wr_word
);
   generate
      if (1 + 3 * RGB_W != HALF_W) begin : g_bad_rgb
         $error("pxpk_packer: key plus three RGB fields must fill a half word");
      end
      if (RGB_W > COMP_W) begin : g_bad_trunc
         $error("pxpk_packer: RGB field wider than component");
      end
   endgenerate

   logic [1:0]         lane_q;
   logic               odd_q;
   logic [WORD_W-1:0]  acc_q;
   logic [WORD_W-1:0]  fill_w;
   logic [WORD_W-1:0]  base_w;
   logic [WORD_W-1:0]  ins_w;
   logic [HALF_W-1:0]  rgb_half;
   logic [HALF_W-1:0]  yuv_half;
   logic [WORD_W-1:0]  grey_w;
   logic               word_done;
   logic               emit;

   pxpk_fill #(.COMP_W(COMP_W)) u_fill (
      .fmt       (fmt),
      .chroma_tc (chroma_tc),
      .fill_word (fill_w)
   );

   // a fresh word starts out holding the fill pattern
   assign base_w   = (lane_q == 2'd0) ? fill_w : acc_q;
   assign rgb_half = {key, r[COMP_W-1 -: RGB_W], g[COMP_W-1 -: RGB_W], b[COMP_W-1 -: RGB_W]};
   assign yuv_half = {y, (lane_q == 2'd0) ? u : v};

   genvar k;
   generate
      for (k = 0; k < 4; k++) begin : g_grey_lane
         assign grey_w[WORD_W-1-k*COMP_W -: COMP_W] =
            (lane_q == 2'(k)) ? y : base_w[WORD_W-1-k*COMP_W -: COMP_W];
      end
   endgenerate

   always_comb begin
      ins_w = base_w;
      case (fmt)
         PK_RGB15: begin
            if (lane_q == 2'd0) ins_w[WORD_W-1 -: HALF_W] = rgb_half;
            else                ins_w[HALF_W-1:0]         = rgb_half;
         end
         PK_YUV2: begin
            if (lane_q == 2'd0) ins_w[WORD_W-1 -: HALF_W] = yuv_half;
            else                ins_w[HALF_W-1:0]         = yuv_half;
         end
         PK_TEST:  ins_w = {y, odd_q ? v : u, {HALF_W{1'b0}}};
         default:  ins_w = grey_w;
      endcase
   end

   assign word_done = keep && (lane_q == last_lane(fmt));
   assign emit      = word_done || (eol && (keep || lane_q != 2'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q  <= '0;
         odd_q   <= 1'b0;
         acc_q   <= '0;
         wr_en   <= 1'b0;
         wr_word <= '0;
      end else begin
         wr_en <= emit;
         if (emit) wr_word <= keep ? ins_w : base_w;
         if (emit || eol) begin
            lane_q <= '0;
         end else if (keep) begin
            lane_q <= lane_q + 2'd1;
            acc_q  <= ins_w;
         end
         if (eol)       odd_q <= 1'b0;
         else if (keep) odd_q <= ~odd_q;
      end
   end

   // R6: every line end returns the lane position to zero
   p_line_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (lane_q == 2'd0 && !odd_q));
   // R5: a pixel closing a line always produces a word
   p_close_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eol && keep) |=> wr_en);
   // R3: a test-format pixel is never held back
   p_test_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (keep && fmt == PK_TEST) |=> wr_en);
endmodule

// File: rtl/pxpk_queue.sv
module pxpk_queue #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int HALF = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic              rd_en,
   output logic [WIDTH-1:0]  rd_data,
   output logic              empty,
   output logic              half,
   output logic              ovf
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("pxpk_queue: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      cnt_q;
   logic             full, push, pop;

   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign empty = (cnt_q == '0);
   assign half  = (cnt_q >= (AW+1)'(HALF));
   assign push  = wr_en && !full;
   assign pop   = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         cnt_q   <= '0;
         rd_data <= '0;
         ovf     <= 1'b0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop) begin
            rp_q    <= rp_q + 1'b1;
            rd_data <= mem[rp_q];
         end
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   // R9: occupancy never exceeds capacity
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (AW+1)'(DEPTH));
   // R9: overflow flag is sticky
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R10: a read of an empty queue leaves the data alone
   p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> $stable(rd_data));
   // R7: a lone accepted write grows occupancy by one
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full && !rd_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pxpk_top.sv
module pxpk_top
   import pxpk_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int RGB_W  = 5,
   parameter int DEPTH  = 16,
   localparam int WORD_W = 4 * COMP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         fmt_sel,
   input  logic               chroma_tc,
   input  logic               pix_keep,
   input  logic               line_last,
   input  logic               pix_key,
   input  logic [COMP_W-1:0]  pix_r,
   input  logic [COMP_W-1:0]  pix_g,
   input  logic [COMP_W-1:0]  pix_b,
   input  logic [COMP_W-1:0]  pix_y,
   input  logic [COMP_W-1:0]  pix_u,
   input  logic [COMP_W-1:0]  pix_v,
   input  logic               rd_en,
   output logic [WORD_W-1:0]  rd_data,
   output logic               q_empty,
   output logic               q_half,
   output logic               q_ovf
);
   logic              pk_wr;
   logic [WORD_W-1:0] pk_word;
   pk_fmt_e           fmt;

   assign fmt = pk_fmt_e'(fmt_sel);

   pxpk_packer #(.COMP_W(COMP_W), .RGB_W(RGB_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (fmt),
      .chroma_tc (chroma_tc),
      .keep      (pix_keep),
      .eol       (line_last),
      .key       (pix_key),
      .r         (pix_r),
      .g         (pix_g),
      .b         (pix_b),
      .y         (pix_y),
      .u         (pix_u),
      .v         (pix_v),
      .wr_en     (pk_wr),
      .wr_word   (pk_word)
   );

   pxpk_queue #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pk_wr),
      .wr_data (pk_word),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .empty   (q_empty),
      .half    (q_half),
      .ovf     (q_ovf)
   );

   // R8: half flag never raised while the queue is empty
   p_half_vs_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_half && q_empty));
endmodule

// File: tb/pxpk_top_test.sv
module pxpk_top_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic        chroma_tc = 1'b0;
   logic        pix_keep = 1'b0;
   logic        line_last = 1'b0;
   logic        pix_key = 1'b0;
   logic [7:0]  pix_r = 0, pix_g = 0, pix_b = 0, pix_y = 0, pix_u = 0, pix_v = 0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        q_empty, q_half, q_ovf;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;
   bit checking = 0;
   string cur_tag = "R11";

   always #(CLK_P/2) clk = ~clk;

   pxpk_top uut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .chroma_tc(chroma_tc),
      .pix_keep(pix_keep), .line_last(line_last), .pix_key(pix_key),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_y(pix_y),
      .pix_u(pix_u), .pix_v(pix_v), .rd_en(rd_en), .rd_data(rd_data),
      .q_empty(q_empty), .q_half(q_half), .q_ovf(q_ovf)
   );

   // ---------------- reference model ----------------
   logic [31:0] mq[$];
   string       tq[$];
   logic [31:0] exp_rd = 0;
   string       exp_tag = "R11";
   bit          exp_ovf = 0;
   bit          pend_v = 0;
   logic [31:0] pend_w = 0;
   string       pend_tag = "";
   int          n_pix = 0;
   int          line_pos = 0;
   logic        ka[4];
   logic [7:0]  ra[4], ga[4], ba[4], ya[4], ua[4], va[4];

   function automatic logic [31:0] build(int f, bit tc, int n);
      logic [31:0] w = 0;
      for (int k = 0; k < 2 && f < 2; k++) begin
         logic [15:0] h;
         if (f == 0) h = (k < n) ? {ka[k], ra[k][7:3], ga[k][7:3], ba[k][7:3]} : 16'h0;
         else        h = (k < n) ? {ya[k], (k == 0) ? ua[k] : va[k]} : {8'h00, tc ? 8'h00 : 8'h80};
         if (k == 0) w[31:16] = h; else w[15:0] = h;
      end
      if (f == 3)
         for (int k = 0; k < 4; k++) w[31-8*k -: 8] = (k < n) ? ya[k] : 8'hFF;
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); tq.delete();
         exp_rd = 0; exp_ovf = 0; pend_v = 0; n_pix = 0; line_pos = 0;
      end else begin
         bit full;
         int lanes;
         full = (mq.size() == 16);
         if (rd_en) begin
            if (mq.size() > 0) begin exp_rd = mq.pop_front(); exp_tag = tq.pop_front(); end
            else exp_tag = cur_tag;
         end
         if (pend_v) begin
            if (!full) begin mq.push_back(pend_w); tq.push_back(pend_tag); end
            else exp_ovf = 1;
         end
         pend_v = 0;
         lanes = (fmt_sel == 3) ? 4 : (fmt_sel == 2) ? 1 : 2;
         if (pix_keep) begin
            if (fmt_sel == 2) begin
               pend_w = {pix_y, (line_pos % 2) ? pix_v : pix_u, 16'h0};
               pend_v = 1; pend_tag = cur_tag;
            end else begin
               ka[n_pix] = pix_key; ra[n_pix] = pix_r; ga[n_pix] = pix_g; ba[n_pix] = pix_b;
               ya[n_pix] = pix_y; ua[n_pix] = pix_u; va[n_pix] = pix_v;
               n_pix++;
               if (n_pix == lanes || line_last) begin
                  pend_w = build(fmt_sel, chroma_tc, n_pix); pend_v = 1; pend_tag = cur_tag; n_pix = 0;
               end
            end
            line_pos++;
         end else if (line_last && n_pix > 0) begin
            pend_w = build(fmt_sel, chroma_tc, n_pix); pend_v = 1; pend_tag = cur_tag; n_pix = 0;
         end
         if (line_last) begin n_pix = 0; line_pos = 0; end
      end
   end

   // ---------------- comparison every cycle ----------------
   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         chk(rd_data === exp_rd, exp_tag, "rd_data", rd_data, exp_rd);
         chk(q_empty === (mq.size() == 0), "R7", "q_empty", 32'(q_empty), 32'(mq.size() == 0));
         chk(q_half === (mq.size() >= 8), "R8", "q_half", 32'(q_half), 32'(mq.size() >= 8));
         chk(q_ovf === exp_ovf, "R9", "q_ovf", 32'(q_ovf), 32'(exp_ovf));
      end
   end

   // ---------------- stimulus ----------------
   task automatic px(input logic [7:0] y, u, v, r, g, b, input logic k, input logic last);
      @(negedge clk);
      pix_keep = 1; line_last = last; pix_y = y; pix_u = u; pix_v = v;
      pix_r = r; pix_g = g; pix_b = b; pix_key = k; rd_en = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pix_keep = 0; line_last = 0; rd_en = 0;
      end
   endtask

   task automatic eol_only();
      @(negedge clk); pix_keep = 0; line_last = 1; rd_en = 0;
   endtask

   task automatic drain(int extra);
      idle(2);
      while (mq.size() > 0) begin @(negedge clk); pix_keep = 0; line_last = 0; rd_en = 1; end
      for (int i = 0; i < extra; i++) begin @(negedge clk); rd_en = 1; end
      idle(1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state, checked while reset is held
      chk(rd_data === 32'h0, "R11", "rd_data", rd_data, 32'h0);
      chk(q_empty === 1'b1, "R11", "q_empty", 32'(q_empty), 32'h1);
      chk(q_half === 1'b0 && q_ovf === 1'b0, "R11", "flags", {30'h0, q_half, q_ovf}, 32'h0);
      rst_n = 1; checking = 1;
      idle(2);

      // R1: RGB, full pairs then a partial pair (R5 fill 0)
      cur_tag = "R1"; fmt_sel = 0;
      px(0, 0, 0, 8'hF8, 8'h07, 8'hA5, 1, 0);
      px(0, 0, 0, 8'h13, 8'hFF, 8'h40, 0, 0);
      px(0, 0, 0, 8'h88, 8'h44, 8'h22, 0, 0);
      px(0, 0, 0, 8'h11, 8'hC3, 8'h3C, 1, 0);
      cur_tag = "R5";
      px(0, 0, 0, 8'hFF, 8'hFF, 8'hFF, 1, 1);
      drain(0);

      // R2: YUV pairs, straight-binary chroma fill (R5)
      cur_tag = "R2"; fmt_sel = 1; chroma_tc = 0;
      px(8'h10, 8'h20, 8'h30, 0, 0, 0, 0, 0);
      px(8'h11, 8'h21, 8'h31, 0, 0, 0, 0, 0);
      cur_tag = "R5";
      px(8'h12, 8'h22, 8'h32, 0, 0, 0, 0, 1);
      chroma_tc = 1;
      px(8'hE0, 8'h7F, 8'h81, 0, 0, 0, 0, 1);
      drain(0);

      // R3: test format, chroma alternates and restarts with the line (R6)
      cur_tag = "R3"; fmt_sel = 2;
      px(8'h01, 8'hA1, 8'hB1, 0, 0, 0, 0, 0);
      px(8'h02, 8'hA2, 8'hB2, 0, 0, 0, 0, 0);
      px(8'h03, 8'hA3, 8'hB3, 0, 0, 0, 0, 1);
      cur_tag = "R6";
      px(8'h04, 8'hA4, 8'hB4, 0, 0, 0, 0, 0);
      eol_only();
      drain(0);

      // R4: grey, six pixels then partial (R5 fill FF)
      cur_tag = "R4"; fmt_sel = 3;
      for (int i = 0; i < 4; i++) px(8'(8'h40 + i), 0, 0, 0, 0, 0, 0, 0);
      cur_tag = "R5";
      px(8'h50, 0, 0, 0, 0, 0, 0, 0);
      px(8'h51, 0, 0, 0, 0, 0, 0, 1);
      // R6: aligned line end writes nothing; lone line end flushes a partial word
      cur_tag = "R6";
      for (int i = 0; i < 4; i++) px(8'(8'h60 + i), 0, 0, 0, 0, 0, 0, 0);
      eol_only();
      px(8'h70, 0, 0, 0, 0, 0, 0, 0);
      idle(2);
      eol_only();
      drain(0);

      // R7/R8/R9: 20 grey words with no reads; then drain plus empty reads (R10)
      cur_tag = "R7";
      for (int i = 0; i < 80; i++) px(8'(i), 0, 0, 0, 0, 0, 0, 0);
      cur_tag = "R10";
      drain(3);

      // R9: overflow remains set after more traffic
      cur_tag = "R7"; fmt_sel = 1;
      px(8'h9A, 8'h9B, 8'h9C, 0, 0, 0, 0, 1);
      cur_tag = "R10";
      drain(2);
      idle(2);
      done = 1;
      checking = 0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule